// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing Ethernet-style frames from system memory to a byte-wide transmit stream. Software builds a ring of 8-byte descriptors in memory. Each descriptor names one data buffer. Software sets the ready flag on the descriptors it wants sent, enables the block and writes the kick register. The walker then fetches descriptors one after another, reads each buffer through a 32-bit word-addressed memory port and streams its bytes out with a valid/ready handshake. A final-byte marker ends each frame. After each buffer it writes the descriptor's first word back with the ready flag cleared, so software can reclaim the buffer.

The walk ends at the first descriptor whose ready flag is clear. The position is kept, so the next kick resumes at that same descriptor. A wrap flag in a descriptor sends the walker back to the ring base instead of the next 8-byte slot. A frame that grows past the configured ceiling is truncated, and the walker reports a babble event. Three single-cycle event pulses (buffer done, frame done, babble) go to the interrupt logic.

Top module: `tx_bd_ring_engine`

## Requirements
- R1: A descriptor at byte address D holds two 32-bit words. The word at D carries the flag field in bits 31:16 and the buffer length in bits 15:0. The word at D+4 carries the buffer's byte address. Memory words are big-endian: the byte at an address with low bits 00 sits in bits 31:24, and the byte with low bits 11 sits in bits 7:0. The buffer's bytes leave on `tx_data` in ascending address order, for any start alignment and any length.
- R2: Flag bit 15 is the ready flag. A fetched descriptor with bit 15 clear ends the walk, and the block issues no further memory request. The next accepted kick fetches that same descriptor first.
- R3: After a descriptor with flag bit 13 (wrap) set, the next descriptor is read at the ring base. Otherwise it is read at the current descriptor address plus 8.
- R4: Flag bit 11 marks the last buffer of a frame. `tx_last` is high exactly with the final byte sent from such a buffer, and the frame byte count then restarts from zero.
- R5: A frame never carries more than MAX_FRAME bytes (2032 by default). If a buffer would push the frame past that ceiling, only the bytes that fit are sent, possibly none, and `evt_tx_babble` pulses for that buffer.
- R6: Every consumed buffer pulses `evt_tx_buf`. A buffer carrying the last flag also pulses `evt_tx_frame`. Each pulse is one cycle long and comes in the cycle after the descriptor write-back is accepted.
- R7: For each consumed buffer the block writes the word at D with bit 15 cleared, the other flag bits unchanged and the fetched length unchanged. This write happens only after every byte of that buffer has been accepted on the stream.
- R8: A write to the kick register (select 2) starts a walk only while bit 1 of the control register (select 0) is set. Otherwise no memory request follows. The kick register always reads as zero.
- R9: A write to the ring base register (select 1) stores the value with bits 1:0 forced to zero and makes it the current descriptor address. Select 1 reads back the stored base.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R11: While `mem_req` is high and `mem_ready` is low, the request, its address, its direction and its write data hold. Each accepted read is answered by exactly one `mem_rvalid`. A walk makes exactly one request per descriptor word and per buffer word it needs.
- R12: After reset, `tx_valid`, `mem_req` and all event outputs are low. The control and base registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 ring base, 2 kick |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (descriptor write-back) |
| mem_addr | output | ADDR_W-2 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| evt_tx_buf | output | 1 | Buffer-done pulse |
| evt_tx_frame | output | 1 | Frame-done pulse |
| evt_tx_babble | output | 1 | Frame ceiling exceeded pulse |

## Verification
The bound checker watches the handshakes on every cycle. It checks that a stalled byte and a stalled memory request hold steady and that write-backs never carry a set ready flag. It checks that frame and babble pulses come only with a buffer pulse and that the bytes between frame ends never exceed the ceiling. The ring-walk behaviour needs the bench's scenarios to show it: byte order for every start alignment and short length, where a walk stops and resumes, the wrap back to the base, truncation with exact babble counts, the written-back words, and the total number of memory requests. The bench checks all of these against a descriptor model of its own, under random stalls on both ports.

// File: rtl/txr_pkg.sv
// Shared constants and types for the transmit descriptor ring walker.
// Assumes flag positions and register selects are fixed for the whole chip.
package txr_pkg;

    localparam int FLAG_READY  = 15;
    localparam int FLAG_WRAP   = 13;
    localparam int FLAG_LAST   = 11;
    localparam int CTRL_ENABLE = 1;

    localparam logic [1:0] RSEL_CTRL   = 2'd0;
    localparam logic [1:0] RSEL_BASE   = 2'd1;
    localparam logic [1:0] RSEL_DEMAND = 2'd2;

    typedef enum logic [3:0] {
        WS_IDLE,
        WS_D0_REQ,
        WS_D0_WAIT,
        WS_D1_REQ,
        WS_D1_WAIT,
        WS_CAP,
        WS_DAT_REQ,
        WS_DAT_WAIT,
        WS_STREAM,
        WS_WB
    } walk_state_e;

endpackage

// File: rtl/txr_regs.sv
// Software-visible registers: control enable, ring base and the kick strobe.
// Also holds the current descriptor pointer. Assumes the walker advances
// the pointer only while it runs and that the base is written only when idle.
module txr_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              adv_valid,
    input  logic [ADDR_W-1:0] adv_ptr,
    output logic              demand,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] cur_ptr
);
    import txr_pkg::*;

    logic enable;
    logic unused_wbit;

    assign unused_wbit = reg_wdata[0];

    // Control register: only the enable bit is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (reg_we && reg_addr == RSEL_CTRL) begin
            enable <= reg_wdata[CTRL_ENABLE];
        end
    end

    // Ring base register, word aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (reg_we && reg_addr == RSEL_BASE) begin
            base <= {reg_wdata[ADDR_W-1:2], 2'b00};
        end
    end

    // Current descriptor pointer: a base write reloads it, the walker advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
        end else if (reg_we && reg_addr == RSEL_BASE) begin
            cur_ptr <= {reg_wdata[ADDR_W-1:2], 2'b00};
        end else if (adv_valid) begin
            cur_ptr <= adv_ptr;
        end
    end

    // Kick strobe, gated by the enable bit.
    always_comb begin
        demand = reg_we && (reg_addr == RSEL_DEMAND) && enable;
    end

    // Read mux; the kick register and the spare select read as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RSEL_CTRL: reg_rdata[CTRL_ENABLE] = enable;
            RSEL_BASE: reg_rdata[ADDR_W-1:0]  = base;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txr_len_cap.sv
// Frame ceiling arithmetic: how many bytes of a buffer still fit in the
// current frame. Assumes frame_bytes never exceeds MAX_FRAME.
module txr_len_cap #(
    parameter int MAX_FRAME = 2032,
    parameter int CW        = $clog2(MAX_FRAME + 1)
) (
    input  logic [CW-1:0] frame_bytes,
    input  logic [15:0]   buf_len,
    output logic [CW-1:0] eff_len,
    output logic          cut
);
    logic [CW-1:0] room;

    // Compare the requested length with the space left and clip it.
    always_comb begin
        room    = CW'(MAX_FRAME) - frame_bytes;
        cut     = {1'b0, buf_len} > 17'(room);
        eff_len = cut ? room : buf_len[CW-1:0];
    end

endmodule

// File: rtl/txr_byte_lane.sv
// Picks one byte out of a big-endian memory word by the address low bits.
// Assumes lane 0 is the most significant byte.
module txr_byte_lane (
    input  logic [31:0] word_i,
    input  logic [1:0]  lane_i,
    output logic [7:0]  byte_o
);
    // Big-endian lane select.
    always_comb begin
        case (lane_i)
            2'd0:    byte_o = word_i[31:24];
            2'd1:    byte_o = word_i[23:16];
            2'd2:    byte_o = word_i[15:8];
            default: byte_o = word_i[7:0];
        endcase
    end

endmodule

// File: rtl/txr_walker.sv
// Descriptor sequencer: fetches both descriptor words, clips the length to
// the frame ceiling, reads the buffer word by word, streams the bytes,
// writes the descriptor back and advances. Assumes one outstanding memory
// request, one rvalid per accepted read, and a stable cur_ptr while busy.
module txr_walker #(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 2032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              demand,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] base,
    output logic              adv_valid,
    output logic [ADDR_W-1:0] adv_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              evt_tx_buf,
    output logic              evt_tx_frame,
    output logic              evt_tx_babble
);
    import txr_pkg::*;

    localparam int CW = $clog2(MAX_FRAME + 1);
    localparam int WW = ADDR_W - 2;

    walk_state_e       state;
    logic [15:0]       flags;
    logic [15:0]       blen;
    logic [ADDR_W-1:0] buf_ptr;
    logic [CW-1:0]     remain;
    logic [CW-1:0]     frame_bytes;
    logic [31:0]       data_word;
    logic              cut_r;
    logic [CW-1:0]     eff_len;
    logic              cut;
    logic [15:0]       wb_flags;

    txr_len_cap #(.MAX_FRAME(MAX_FRAME), .CW(CW)) u_cap (
        .frame_bytes(frame_bytes),
        .buf_len    (blen),
        .eff_len    (eff_len),
        .cut        (cut)
    );

    txr_byte_lane u_lane (
        .word_i(data_word),
        .lane_i(buf_ptr[1:0]),
        .byte_o(tx_data)
    );

    // Main sequencer and its datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= WS_IDLE;
            flags       <= '0;
            blen        <= '0;
            buf_ptr     <= '0;
            remain      <= '0;
            frame_bytes <= '0;
            data_word   <= '0;
            cut_r       <= 1'b0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (demand) state <= WS_D0_REQ;
                end
                WS_D0_REQ: begin
                    if (mem_ready) state <= WS_D0_WAIT;
                end
                WS_D0_WAIT: begin
                    if (mem_rvalid) begin
                        flags <= mem_rdata[31:16];
                        blen  <= mem_rdata[15:0];
                        state <= mem_rdata[16 + FLAG_READY] ? WS_D1_REQ : WS_IDLE;
                    end
                end
                WS_D1_REQ: begin
                    if (mem_ready) state <= WS_D1_WAIT;
                end
                WS_D1_WAIT: begin
                    if (mem_rvalid) begin
                        buf_ptr <= mem_rdata[ADDR_W-1:0];
                        state   <= WS_CAP;
                    end
                end
                WS_CAP: begin
                    remain      <= eff_len;
                    cut_r       <= cut;
                    frame_bytes <= frame_bytes + eff_len;
                    state       <= (eff_len == '0) ? WS_WB : WS_DAT_REQ;
                end
                WS_DAT_REQ: begin
                    if (mem_ready) state <= WS_DAT_WAIT;
                end
                WS_DAT_WAIT: begin
                    if (mem_rvalid) begin
                        data_word <= mem_rdata;
                        state     <= WS_STREAM;
                    end
                end
                WS_STREAM: begin
                    if (tx_ready) begin
                        buf_ptr <= buf_ptr + ADDR_W'(1);
                        remain  <= remain - CW'(1);
                        if (remain == CW'(1)) begin
                            state <= WS_WB;
                        end else if (buf_ptr[1:0] == 2'd3) begin
                            state <= WS_DAT_REQ;
                        end
                    end
                end
                WS_WB: begin
                    if (mem_ready) begin
                        if (flags[FLAG_LAST]) frame_bytes <= '0;
                        state <= WS_D0_REQ;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // Event pulses, one cycle after the write-back is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_tx_buf    <= 1'b0;
            evt_tx_frame  <= 1'b0;
            evt_tx_babble <= 1'b0;
        end else begin
            evt_tx_buf    <= adv_valid;
            evt_tx_frame  <= adv_valid && flags[FLAG_LAST];
            evt_tx_babble <= adv_valid && cut_r;
        end
    end

    // Write-back flags: ready cleared, everything else kept.
    always_comb begin
        wb_flags             = flags;
        wb_flags[FLAG_READY] = 1'b0;
    end

    // Memory request decode.
    always_comb begin
        mem_req   = (state == WS_D0_REQ) || (state == WS_D1_REQ) ||
                    (state == WS_DAT_REQ) || (state == WS_WB);
        mem_we    = (state == WS_WB);
        mem_wdata = {wb_flags, blen};
        case (state)
            WS_D0_REQ, WS_WB: mem_addr = cur_ptr[ADDR_W-1:2];
            WS_D1_REQ:        mem_addr = cur_ptr[ADDR_W-1:2] + WW'(1);
            WS_DAT_REQ:       mem_addr = buf_ptr[ADDR_W-1:2];
            default:          mem_addr = '0;
        endcase
    end

    // Stream outputs and pointer advance.
    always_comb begin
        tx_valid  = (state == WS_STREAM);
        tx_last   = (state == WS_STREAM) && flags[FLAG_LAST] && (remain == CW'(1));
        adv_valid = (state == WS_WB) && mem_ready;
        adv_ptr   = flags[FLAG_WRAP] ? base : cur_ptr + ADDR_W'(8);
    end

endmodule

// File: rtl/tx_bd_ring_engine.sv
// Top of the transmit descriptor ring walker: register block plus sequencer.
// Assumes a memory that accepts one request at a time on mem_ready and
// returns read data later with a single mem_rvalid.
module tx_bd_ring_engine #(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 2032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              evt_tx_buf,
    output logic              evt_tx_frame,
    output logic              evt_tx_babble
);
    logic              demand;
    logic              adv_valid;
    logic [ADDR_W-1:0] adv_ptr;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] cur_ptr;

    txr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .adv_valid(adv_valid),
        .adv_ptr  (adv_ptr),
        .demand   (demand),
        .base     (base),
        .cur_ptr  (cur_ptr)
    );

    txr_walker #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .demand       (demand),
        .cur_ptr      (cur_ptr),
        .base         (base),
        .adv_valid    (adv_valid),
        .adv_ptr      (adv_ptr),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_last      (tx_last),
        .tx_ready     (tx_ready),
        .evt_tx_buf   (evt_tx_buf),
        .evt_tx_frame (evt_tx_frame),
        .evt_tx_babble(evt_tx_babble)
    );

endmodule

// File: rtl/txr_checker.sv
// Protocol and ceiling checks for the ring walker, bound to its top.
// Assumes the same parameters as the bound instance.
module txr_checker #(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 2032
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready,
    input logic              evt_tx_buf,
    input logic              evt_tx_frame,
    input logic              evt_tx_babble
);
    int frame_cnt;

    // Bytes seen since the last frame-done pulse must stay under the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= 0;
        end else begin
            a_r5_frame_ceiling: assert (frame_cnt <= MAX_FRAME)
                else $error("frame exceeded ceiling");
            if (evt_tx_frame) frame_cnt <= 0;
            else if (tx_valid && tx_ready) frame_cnt <= frame_cnt + 1;
        end
    end

    a_r10_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    a_r4_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    a_r11_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

    a_r7_writeback_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    a_r7_no_write_while_streaming: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tx_valid));

    a_r6_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_frame |-> evt_tx_buf);

    a_r5_babble_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_babble |-> evt_tx_buf);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_buf |=> !evt_tx_buf);

endmodule

bind tx_bd_ring_engine txr_checker #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ready    (mem_ready),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .tx_ready     (tx_ready),
    .evt_tx_buf   (evt_tx_buf),
    .evt_tx_frame (evt_tx_frame),
    .evt_tx_babble(evt_tx_babble)
);

// File: tb/test_tx_bd_ring_engine.sv
`timescale 1ns/1ps
module test_tx_bd_ring_engine;
    localparam int AW   = 32;
    localparam int MAXF = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [AW-3:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        evt_tx_buf, evt_tx_frame, evt_tx_babble;

    tx_bd_ring_engine #(.ADDR_W(AW), .MAX_FRAME(MAXF)) i_tx_bd_ring_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .evt_tx_buf(evt_tx_buf), .evt_tx_frame(evt_tx_frame), .evt_tx_babble(evt_tx_babble)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mem [0:511];
    logic [7:0]  exp_byte [0:1023];
    logic        exp_last [0:1023];
    int exp_n = 0, got_n = 0;
    int exp_txb = 0, exp_txf = 0, exp_babt = 0, exp_req = 0;
    int got_txb = 0, got_txf = 0, got_babt = 0, req_count = 0;
    int frame_m = 0;
    int wb_word [0:63];
    logic [31:0] wb_val [0:63];
    int wb_n = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic rd_pend = 1'b0;
    int   rd_word = 0;
    logic wb_prev = 1'b0;
    logic arm_first = 1'b0;
    int   first_rd = -1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'(a ^ (a >> 3) ^ 8'hA5);
    endfunction

    // Memory model, stall generator and stream monitor, all away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_tx_buf) got_txb++;
            if (evt_tx_frame) got_txf++;
            if (evt_tx_babble) got_babt++;
            if (wb_prev) chk("R6 pulse after write-back", 32'(evt_tx_buf), 32'd1);
        end
        mem_rvalid = rd_pend;
        mem_rdata  = rd_pend ? mem[rd_word] : 32'h0;
        rd_pend    = 1'b0;
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready  = rst_n && (lfsr[5] | lfsr[1]);
        tx_ready   = rst_n && (lfsr[0] | lfsr[3]);
        wb_prev    = 1'b0;
        if (mem_req && mem_ready) begin
            req_count++;
            if (mem_we) begin
                mem[int'(mem_addr[8:0])] = mem_wdata;
                wb_prev = 1'b1;
            end else begin
                rd_pend = 1'b1;
                rd_word = int'(mem_addr[8:0]);
                if (arm_first) begin
                    first_rd  = int'(mem_addr[8:0]);
                    arm_first = 1'b0;
                end
            end
        end
        if (tx_valid && tx_ready) begin
            if (got_n < exp_n) begin
                chk("R1 byte", 32'(tx_data), 32'(exp_byte[got_n]));
                chk("R4 last marker", 32'(tx_last), 32'(exp_last[got_n]));
            end else begin
                chk("R1 unexpected byte", 32'(got_n), 32'(exp_n));
            end
            got_n++;
        end
    end

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Writes a descriptor and advances the bench's own expectation model.
    task automatic put_desc(int idx, logic [15:0] fl, int len, int bufa);
        int d = 'h100 + 8 * idx;
        int eff;
        mem[d >> 2]       = {fl, 16'(len)};
        mem[(d >> 2) + 1] = 32'(bufa);
        if (fl[15]) begin
            eff = len;
            if (frame_m + len > MAXF) begin
                eff = MAXF - frame_m;
                exp_babt++;
            end
            for (int k = 0; k < eff; k++) begin
                exp_byte[exp_n] = pat(bufa + k);
                exp_last[exp_n] = fl[11] && (k == eff - 1);
                exp_n++;
            end
            exp_req += 3;
            if (eff > 0) exp_req += ((bufa + eff - 1) >> 2) - (bufa >> 2) + 1;
            frame_m += eff;
            if (fl[11]) begin
                frame_m = 0;
                exp_txf++;
            end
            exp_txb++;
            wb_word[wb_n] = d >> 2;
            wb_val[wb_n]  = {fl & 16'h7FFF, 16'(len)};
            wb_n++;
        end
    endtask

    // Kicks the walker and waits for the model's event and request totals.
    task automatic kick_and_wait();
        int t = 0;
        exp_req += 1;
        arm_first = 1'b1;
        reg_write(2'd2, 32'h0);
        while ((got_txb != exp_txb || req_count != exp_req) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic check_run(string tag);
        chk({"R1 byte count ", tag}, 32'(got_n), 32'(exp_n));
        chk({"R10 stream complete under stalls ", tag}, 32'(got_n), 32'(exp_n));
        chk({"R11 request count ", tag}, 32'(req_count), 32'(exp_req));
        chk({"R6 buffer events ", tag}, 32'(got_txb), 32'(exp_txb));
        chk({"R6 frame events ", tag}, 32'(got_txf), 32'(exp_txf));
        chk({"R5 babble events ", tag}, 32'(got_babt), 32'(exp_babt));
        for (int i = 0; i < wb_n; i++)
            chk({"R7 write-back ", tag}, mem[wb_word[i]], wb_val[i]);
        wb_n = 0;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: act hung exp finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int req_before;
        for (int w = 0; w < 512; w++)
            mem[w] = {pat(4*w), pat(4*w+1), pat(4*w+2), pat(4*w+3)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        chk("R12 tx_valid", 32'(tx_valid), 32'd0);
        chk("R12 mem_req", 32'(mem_req), 32'd0);
        chk("R12 events", 32'({evt_tx_buf, evt_tx_frame, evt_tx_babble}), 32'd0);
        reg_read(2'd0, rd); chk("R12 control", rd, 32'h0);
        reg_read(2'd1, rd); chk("R12 base", rd, 32'h0);

        // R9 base alignment; R8 kick reads zero and is ignored while disabled
        reg_write(2'd1, 32'h0000_0103);
        reg_read(2'd1, rd); chk("R9 base low bits", rd, 32'h0000_0100);
        reg_read(2'd2, rd); chk("R8 kick reads zero", rd, 32'h0);
        req_before = req_count;
        reg_write(2'd2, 32'hFFFF_FFFF);
        repeat (30) @(negedge clk);
        chk("R8 kick ignored when disabled", 32'(req_count), 32'(req_before));
        reg_write(2'd0, 32'h2);
        reg_read(2'd0, rd); chk("R8 enable readback", rd, 32'h2);

        // R1/R4/R6/R7 sweep: every alignment with lengths 0..5, one buffer per frame
        for (int i = 0; i < 24; i++)
            put_desc(i, 16'h8800 | ((i % 2) ? 16'h1000 : 16'h0), i / 4, 'h200 + 8*i + (i % 4));
        mem[('h100 + 8*24) >> 2] = 32'h0;
        kick_and_wait();
        check_run("sweep");
        chk("R9 walk starts at base", 32'(first_rd), 32'('h100 >> 2));

        // R2 stop kept: a new kick fetches the same not-ready descriptor first
        kick_and_wait();
        chk("R2 resume at stopped descriptor", 32'(first_rd), 32'(('h100 + 8*24) >> 2));
        check_run("resume");

        // R3 wrap: descriptor 24 wraps to the base, descriptor 1 then stops the walk
        put_desc(24, 16'hA800, 3, 'h300);
        put_desc(0, 16'h8800, 4, 'h305);
        kick_and_wait();
        check_run("wrap");
        kick_and_wait();
        chk("R3 base then plus eight", 32'(first_rd), 32'(('h100 + 8) >> 2));

        // R5 ceiling: cut mid-buffer, exact fit, cut to zero, then a fresh frame
        reg_write(2'd1, 32'h0000_0100);
        put_desc(0, 16'h8000, 15, 'h400);
        put_desc(1, 16'h8000, 15, 'h410);
        put_desc(2, 16'h8800, 15, 'h420);
        put_desc(3, 16'h8000, 20, 'h440);
        put_desc(4, 16'h8800, 20, 'h460);
        put_desc(5, 16'h8000, 40, 'h480);
        put_desc(6, 16'h8800, 5, 'h4B0);
        put_desc(7, 16'h8800, 3, 'h4C1);
        mem[('h100 + 8*8) >> 2] = 32'h0;
        kick_and_wait();
        chk("R9 reload restarts at base", 32'(first_rd), 32'('h100 >> 2));
        check_run("ceiling");
        chk("R5 two truncations", 32'(got_babt), 32'd2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule